// File: doc/BRIEF.md
# Video line sync sequencer

This block generates composite sync for a 625-line interlaced video frame. It contains a small PWM-style timer and a slot sequencer that drives it. The timer counts ticks from zero up to a period value and then wraps. The sync output goes low on every wrap and goes high again when the count reaches a compare value. Period and compare sit in double-buffered registers. The sequencer fills the preload copies while one slot is running, and the timer moves them into its working copies at the next wrap.

The sequencer walks through the slots of a field in a fixed order: equalizing half-lines, broad-sync half-lines, more equalizing half-lines, and then full-length normal lines. Any line that carries two sync pulses is handled as two separate half-length slots, each with its own period and low time. When the last slot of a field finishes, the sequence starts again from the first slot and the field flag toggles. Because each field contains an odd number of half-lines, the two fields add up to the interlaced line total.

A one-cycle strobe marks the start of active video on picture-carrying normal lines, for use by a later pixel stage. A tick-enable input lets the block run from a prescaled time base.

Top module: `vsync_gen`

## Requirements
- R1: During and straight after reset: `sync_n` is 0, `slot_start` is 0, `act_stb` is 0, `field_odd` is 0, and `slot_kind` reports the first slot (equalizing, code 1).
- R2: Every slot begins with `sync_n` falling to 0 on the tick that wraps the counter. `slot_start` is 1 for exactly the one clock cycle that follows that wrap edge.
- R3: `sync_n` stays 0 for a number of ticks that depends on the slot kind: NORM_LOW for normal, EQ_LOW for equalizing and BROAD_LOW for broad-sync. It returns to 1 on the edge where the tick count reaches that value.
- R4: A normal slot lasts FULL_TICKS ticks. Equalizing and broad-sync slots last HALF_TICKS ticks.
- R5: Within a field the slot order is HALF_GROUP equalizing, HALF_GROUP broad-sync, HALF_GROUP equalizing, then NORM_LINES normal. `slot_kind` reports the running slot as 0 = normal, 1 = equalizing, 2 = broad-sync.
- R6: The timer advances only on cycles with `tick_en` = 1. On cycles with `tick_en` = 0, all outputs hold their values. Period and compare for the next slot are written into preload registers during the current slot and take effect only at the wrap.
- R7: On normal slots whose line number within the normal group is BLANK_LINES or more, `act_stb` pulses for one cycle when the tick count first equals the slot's low time plus ACT_DELAY. On all other slots it stays 0.
- R8: After the last slot of a field, the sequence returns to the first slot and `field_odd` toggles. With the default parameters the two fields together span 625 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advances one tick on cycles where this is 1 |
| sync_n | output | 1 | Composite sync, 0 during the sync pulse |
| slot_start | output | 1 | One-cycle pulse on the first cycle of each slot |
| slot_kind | output | 2 | Kind of the running slot: 0 normal, 1 equalizing, 2 broad-sync |
| field_odd | output | 1 | Field flag, toggles at each field restart |
| act_stb | output | 1 | One-cycle start-of-active-video strobe |

## Verification
On every cycle, the assertions check local timer invariants: the count stays below the active period, sync is low whenever a slot starts, sync rises only at the compare value, state holds while ticks are gated, preload registers change only right after a wrap, and the strobe lands at its fixed offset. Only the bench's cycle-accurate reference model of the slot order can show whether the sequence is right. That model covers which kind follows which, per-kind low times and periods, blank versus picture lines, field toggling, and the one-slot-ahead loading seen at the ports. The bench runs this model under random tick gating and long gated stretches.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

  // Kind of a sequencer slot; the code is visible on the slot_kind port.
  typedef enum logic [1:0] {
    SK_NORMAL = 2'd0,
    SK_EQ     = 2'd1,
    SK_BROAD  = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/vsync_slot_seq.sv
module vsync_slot_seq
  import vsync_pkg::*;
#(
  parameter int FULL_TICKS  = 1024,
  parameter int HALF_TICKS  = 512,
  parameter int NORM_LOW    = 75,
  parameter int EQ_LOW      = 38,
  parameter int BROAD_LOW   = 437,
  parameter int HALF_GROUP  = 5,
  parameter int NORM_LINES  = 305,
  parameter int BLANK_LINES = 18,
  parameter int W           = 11,
  parameter int SLOTS       = 320,
  parameter int PW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [W-1:0]  pre_per_o,
  output logic [W-1:0]  pre_cmp_o,
  output logic [1:0]    pre_kind_o,
  output logic          pre_act_o,
  output logic          pre_fld_o
);

  // Position of the slot whose values currently sit in the preload registers.
  logic [PW-1:0] pos_q, pos_d;
  logic          fld_q, fld_d;

  function automatic slot_kind_e kind_of(input int p);
    if (p < HALF_GROUP)          return SK_EQ;
    else if (p < 2 * HALF_GROUP) return SK_BROAD;
    else if (p < 3 * HALF_GROUP) return SK_EQ;
    else                         return SK_NORMAL;
  endfunction

  function automatic logic [W-1:0] per_of(input int p);
    return (kind_of(p) == SK_NORMAL) ? W'(FULL_TICKS) : W'(HALF_TICKS);
  endfunction

  function automatic logic [W-1:0] low_of(input int p);
    case (kind_of(p))
      SK_NORMAL: return W'(NORM_LOW);
      SK_BROAD:  return W'(BROAD_LOW);
      default:   return W'(EQ_LOW);
    endcase
  endfunction

  function automatic logic act_of(input int p);
    return p >= 3 * HALF_GROUP + BLANK_LINES;
  endfunction

  always_comb begin
    if (pos_q == PW'(SLOTS - 1)) begin
      pos_d = '0;
      fld_d = ~fld_q;
    end else begin
      pos_d = pos_q + 1'b1;
      fld_d = fld_q;
    end
  end

  // Reset leaves slot 0 running in the timer and slot 1 waiting in preload.
  // On each slot start the slot after the running one is loaded.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= PW'(1);
      fld_q      <= 1'b0;
      pre_per_o  <= per_of(1);
      pre_cmp_o  <= low_of(1);
      pre_kind_o <= kind_of(1);
      pre_act_o  <= act_of(1);
      pre_fld_o  <= 1'b0;
    end else if (adv_i) begin
      pos_q      <= pos_d;
      fld_q      <= fld_d;
      pre_per_o  <= per_of(int'(pos_d));
      pre_cmp_o  <= low_of(int'(pos_d));
      pre_kind_o <= kind_of(int'(pos_d));
      pre_act_o  <= act_of(int'(pos_d));
      pre_fld_o  <= fld_d;
    end
  end

  assert_pos_in_field_R5: assert property (@(posedge clk) disable iff (rst)
    pos_q < PW'(SLOTS));

  assert_preload_written_after_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pre_per_o) || !$stable(pre_cmp_o)) |-> $past(adv_i));

endmodule

// File: rtl/vsync_timer.sv
module vsync_timer
  import vsync_pkg::*;
#(
  parameter int W       = 11,
  parameter int RST_PER = 512,
  parameter int RST_CMP = 38
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] pre_per_i,
  input  logic [W-1:0] pre_cmp_i,
  input  logic [1:0]   pre_kind_i,
  input  logic         pre_act_i,
  input  logic         pre_fld_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         act_o,
  output logic [1:0]   kind_o,
  output logic         fld_o,
  output logic         sync_n_o,
  output logic         start_o
);

  logic [W-1:0] per_q;
  logic         wrap;

  assign wrap = (cnt_o == per_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      per_q    <= W'(RST_PER);
      cmp_o    <= W'(RST_CMP);
      kind_o   <= SK_EQ;
      act_o    <= 1'b0;
      fld_o    <= 1'b0;
      sync_n_o <= 1'b0;
      start_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (tick_en) begin
        if (wrap) begin
          // Update event: working copies take the preloaded slot.
          cnt_o    <= '0;
          per_q    <= pre_per_i;
          cmp_o    <= pre_cmp_i;
          kind_o   <= pre_kind_i;
          act_o    <= pre_act_i;
          fld_o    <= pre_fld_i;
          sync_n_o <= 1'b0;
          start_o  <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
          if (cnt_o + 1'b1 == cmp_o) sync_n_o <= 1'b1;
        end
      end
    end
  end

  assert_cnt_below_period_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_o < per_q);

  assert_slot_opens_low_R2: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (!sync_n_o && cnt_o == '0));

  assert_rise_at_compare_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n_o) |-> (cnt_o == cmp_o));

  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(cnt_o) && $stable(sync_n_o) && !start_o));

endmodule

// File: rtl/vsync_act_strobe.sv
module vsync_act_strobe #(
  parameter int W         = 11,
  parameter int ACT_DELAY = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         act_i,
  output logic         stb_o
);

  logic [W:0] target;
  assign target = {1'b0, cmp_i} + (W+1)'(ACT_DELAY);

  // Fires on the edge where the count steps onto the target.
  always_ff @(posedge clk) begin
    if (rst) stb_o <= 1'b0;
    else     stb_o <= tick_en && act_i && ({1'b0, cnt_i} + 1'b1 == target);
  end

  assert_strobe_offset_R7: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> (act_i && {1'b0, cnt_i} == target));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);

endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
  import vsync_pkg::*;
#(
  parameter int FULL_TICKS  = 1024,
  parameter int HALF_TICKS  = 512,
  parameter int NORM_LOW    = 75,
  parameter int EQ_LOW      = 38,
  parameter int BROAD_LOW   = 437,
  parameter int HALF_GROUP  = 5,
  parameter int NORM_LINES  = 305,
  parameter int BLANK_LINES = 18,
  parameter int ACT_DELAY   = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  output logic       sync_n,
  output logic       slot_start,
  output logic [1:0] slot_kind,
  output logic       field_odd,
  output logic       act_stb
);

  localparam int W     = $clog2(FULL_TICKS + 1);
  localparam int SLOTS = 3 * HALF_GROUP + NORM_LINES;
  localparam int PW    = $clog2(SLOTS + 1);

  logic [W-1:0] pre_per, pre_cmp, cnt, cmp;
  logic [1:0]   pre_kind;
  logic         pre_act, pre_fld, act_line;

  vsync_slot_seq #(
    .FULL_TICKS (FULL_TICKS),
    .HALF_TICKS (HALF_TICKS),
    .NORM_LOW   (NORM_LOW),
    .EQ_LOW     (EQ_LOW),
    .BROAD_LOW  (BROAD_LOW),
    .HALF_GROUP (HALF_GROUP),
    .NORM_LINES (NORM_LINES),
    .BLANK_LINES(BLANK_LINES),
    .W          (W),
    .SLOTS      (SLOTS),
    .PW         (PW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (slot_start),
    .pre_per_o (pre_per),
    .pre_cmp_o (pre_cmp),
    .pre_kind_o(pre_kind),
    .pre_act_o (pre_act),
    .pre_fld_o (pre_fld)
  );

  vsync_timer #(
    .W      (W),
    .RST_PER(HALF_TICKS),
    .RST_CMP(EQ_LOW)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .pre_per_i (pre_per),
    .pre_cmp_i (pre_cmp),
    .pre_kind_i(pre_kind),
    .pre_act_i (pre_act),
    .pre_fld_i (pre_fld),
    .cnt_o     (cnt),
    .cmp_o     (cmp),
    .act_o     (act_line),
    .kind_o    (slot_kind),
    .fld_o     (field_odd),
    .sync_n_o  (sync_n),
    .start_o   (slot_start)
  );

  vsync_act_strobe #(
    .W        (W),
    .ACT_DELAY(ACT_DELAY)
  ) u_stb (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .cnt_i  (cnt),
    .cmp_i  (cmp),
    .act_i  (act_line),
    .stb_o  (act_stb)
  );

endmodule

// File: tb/vsync_gen_tb.sv
module vsync_gen_tb;

  localparam int FULL  = 40;
  localparam int HALF  = 20;
  localparam int NLOW  = 4;
  localparam int ELOW  = 2;
  localparam int BLOW  = 17;
  localparam int GRP   = 2;
  localparam int NLIN  = 6;
  localparam int BLNK  = 2;
  localparam int DLY   = 3;
  localparam int SLOTS = 3 * GRP + NLIN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic sync_n, slot_start, field_odd, act_stb;
  logic [1:0] slot_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference state
  int m_pos, m_fld, m_cnt;
  bit m_start, m_stb;

  always #2 clk = ~clk;

  vsync_gen #(
    .FULL_TICKS(FULL), .HALF_TICKS(HALF), .NORM_LOW(NLOW), .EQ_LOW(ELOW),
    .BROAD_LOW(BLOW), .HALF_GROUP(GRP), .NORM_LINES(NLIN),
    .BLANK_LINES(BLNK), .ACT_DELAY(DLY)
  ) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sync_n(sync_n),
    .slot_start(slot_start), .slot_kind(slot_kind), .field_odd(field_odd),
    .act_stb(act_stb)
  );

  // Expected slot properties from R3, R4, R5, R7.
  function automatic int kind_exp(input int p);
    if (p < GRP) return 1;
    if (p < 2 * GRP) return 2;
    if (p < 3 * GRP) return 1;
    return 0;
  endfunction
  function automatic int per_exp(input int p);
    return kind_exp(p) == 0 ? FULL : HALF;
  endfunction
  function automatic int low_exp(input int p);
    case (kind_exp(p))
      0: return NLOW;
      2: return BLOW;
      default: return ELOW;
    endcase
  endfunction
  function automatic bit act_exp(input int p);
    return p >= 3 * GRP + BLNK;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R4 slot_start", int'(slot_start), int'(m_start));
    chk("R3 sync_n", int'(sync_n), int'(m_cnt >= low_exp(m_pos)));
    chk("R5 slot_kind", int'(slot_kind), kind_exp(m_pos));
    chk("R8 field_odd", int'(field_odd), m_fld);
    chk("R7 act_stb", int'(act_stb), int'(m_stb));
  endtask

  // One clock: the tick value applied at the edge drives the model update.
  task automatic step(input bit t);
    tick_en = t;
    @(posedge clk);
    m_start = 1'b0;
    m_stb   = 1'b0;
    if (t) begin
      if (m_cnt == per_exp(m_pos) - 1) begin
        m_cnt   = 0;
        m_start = 1'b1;
        if (m_pos == SLOTS - 1) begin
          m_pos = 0;
          m_fld = 1 - m_fld;
        end else begin
          m_pos++;
        end
      end else begin
        m_cnt++;
        m_stb = act_exp(m_pos) && (m_cnt == low_exp(m_pos) + DLY);
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int seed;
    int r;
    seed = 32'd1357;
    r = $urandom(seed);
    m_pos = 0; m_fld = 0; m_cnt = 0; m_start = 1'b0; m_stb = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 sync_n", int'(sync_n), 0);
    chk("R1 slot_start", int'(slot_start), 0);
    chk("R1 act_stb", int'(act_stb), 0);
    chk("R1 field_odd", int'(field_odd), 0);
    chk("R1 slot_kind", int'(slot_kind), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sync_n after release", int'(sync_n), 0);
    chk("R1 slot_kind after release", int'(slot_kind), 1);

    // Directed: free-running ticks across more than a full field (R4, R5, R8).
    for (int i = 0; i < 450; i++) step(1'b1);

    // Random tick gating, dense.
    for (int i = 0; i < 1500; i++) step($urandom_range(99, 0) < 75);

    // R6: long gated stretch, outputs must hold.
    begin
      logic s0; logic [1:0] k0; logic f0;
      s0 = sync_n; k0 = slot_kind; f0 = field_odd;
      for (int i = 0; i < 40; i++) begin
        step(1'b0);
        chk("R6 hold sync_n", int'(sync_n), int'(s0));
        chk("R6 hold slot_kind", int'(slot_kind), int'(k0));
        chk("R6 hold field_odd", int'(field_odd), int'(f0));
        chk("R6 no slot_start", int'(slot_start), 0);
      end
    end

    // Random tick gating, sparse, across further fields (R8 wrap to first slot).
    for (int i = 0; i < 1800; i++) step($urandom_range(99, 0) < 50);

    // Directed: single ticks separated by idle cycles.
    for (int i = 0; i < 200; i++) begin
      step(1'b1);
      step(1'b0);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule